// File: doc/BRIEF.md
# Latency-Scheduled VLIW Register Writeback

This block is the general register file of a VLIW datapath that issues one multi-slot bundle per clock. Every slot has its own read ports, and all of them are sampled from the register state as it stands at the start of the issue cycle. A write from the same bundle never shows up in that cycle's reads. Each slot also presents a destination index, a guard predicate selector, an operation class (plain or load) and, for plain operations, its result value.

Plain results commit at the clock edge that closes the issue cycle, so the next bundle sees them. A load only reserves its destination at issue. Its data arrives on a per-slot load-data input during the following cycle, and it commits at the edge that closes that cycle, two cycles after issue. Predicate squashing is decided at issue. Guard selector 0 is treated as always true. When several writes land on one register at the same edge, a newer operation beats an older one, and within the same age the higher slot wins. There is no interlock: a bundle that reads a register with a load still in flight gets the old value.

Top module: `vliw_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to 0 and discards any load that is in flight, so that load's data never commits.
- R2: Each read port returns the register state from the start of the current cycle. A write issued in the same bundle is not visible on any read port in that cycle.
- R3: An operation with op_valid=1, op_load=0 and a true guard writes op_res to op_dst at the end of its issue cycle, so the next bundle reads the new value.
- R4: An operation with op_load=1 and a true guard takes ld_data of its slot during the cycle after issue and commits it at the end of that cycle. It is visible two bundles after issue and not one bundle after.
- R5: If the selected predicate bit is 0, the operation (plain or load) writes nothing at any later cycle.
- R6: Guard selector value 0 always counts as true, whatever pred_bits[0] holds. pred_bits[k] is the guard for selector k, and selectors are PW bits per slot, with slot 0 in the low bits.
- R7: When two plain operations of one bundle target the same register, the result of the higher-numbered slot is kept.
- R8: When a pending load and a plain operation from the next bundle commit to the same register at the same edge, the plain (newer) result is kept.
- R9: A slot with op_valid=0 writes nothing, whatever its other inputs hold.
- R10: A load in flight stays pending while the following bundle reads the stale value, with no stall, and it still commits on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | NSLOT*NRP*AW | Read indices, slot 0 port 0 in the low bits |
| rd_data | output | NSLOT*NRP*W | Read values, same packing as rd_addr |
| op_valid | input | NSLOT | Slot carries an operation |
| op_load | input | NSLOT | 1 = load class (2-cycle), 0 = plain (1-cycle) |
| op_pidx | input | NSLOT*PW | Guard predicate selector per slot |
| pred_bits | input | NPRED | Predicate values; bit 0 is ignored |
| op_dst | input | NSLOT*AW | Destination index per slot |
| op_res | input | NSLOT*W | Plain-operation result per slot |
| ld_data | input | NSLOT*W | Load data for the load issued by that slot in the previous cycle |

## Verification
The bench targets the timing edges first. It reads a register in the same bundle that writes it, where a design that forwards would return the new value too early. It also reads a load's destination one bundle after issue, where a design that commits loads after one cycle would show the load data early. Squashed plain and squashed load operations are both checked, and both of them get a valid result or load data, so a design that tested the guard only at commit would let the value through. The two collision orders (same-bundle slots, and older load against newer plain) are checked on one register each, where a wrong priority keeps the losing value. A reset with a load in flight checks that the pending write is flushed and does not land afterwards.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int VRF_W     = 16;
    localparam int VRF_NREG  = 16;
    localparam int VRF_NSLOT = 2;
    localparam int VRF_NRP   = 2;
    localparam int VRF_NPRED = 4;

    typedef enum logic {
        OPC_PLAIN = 1'b0,
        OPC_LOAD  = 1'b1
    } op_class_e;
endpackage

// File: rtl/vrf_pred_gate.sv
module vrf_pred_gate #(
    parameter int NSLOT = 2,
    parameter int NPRED = 4,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] op_valid,
    input  logic [NSLOT-1:0] op_load,
    input  logic [NSLOT*PW-1:0] op_pidx,
    input  logic [NPRED-1:0] pred_bits,
    output logic [NSLOT-1:0] plain_en,
    output logic [NSLOT-1:0] load_en
);
    import vrf_pkg::*;

    logic [NPRED-1:0] guard_vec;
    logic [NSLOT-1:0] guard_ok;

    always_comb begin
        guard_vec    = pred_bits;
        guard_vec[0] = 1'b1;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        op_class_e cls;
        always_comb begin
            cls         = op_class_e'(op_load[s]);
            guard_ok[s] = guard_vec[op_pidx[s*PW +: PW]];
            plain_en[s] = op_valid[s] && guard_ok[s] && (cls == OPC_PLAIN);
            load_en[s]  = op_valid[s] && guard_ok[s] && (cls == OPC_LOAD);
        end

        // R5: a false guard on a nonzero selector stops both write kinds
        a_r5_squash: assert property (@(posedge clk) disable iff (rst)
            (op_pidx[s*PW +: PW] != '0 && !pred_bits[op_pidx[s*PW +: PW]])
                |-> (!plain_en[s] && !load_en[s]));

        // R6: selector 0 with a valid op always enables one write kind
        a_r6_p0_true: assert property (@(posedge clk) disable iff (rst)
            (op_valid[s] && op_pidx[s*PW +: PW] == '0)
                |-> $countones({plain_en[s], load_en[s]}) == 1);

        // R9: an invalid slot never enables a write
        a_r9_invalid: assert property (@(posedge clk) disable iff (rst)
            !op_valid[s] |-> (!plain_en[s] && !load_en[s]));
    end
endmodule

// File: rtl/vrf_load_pipe.sv
module vrf_load_pipe #(
    parameter int NSLOT = 2,
    parameter int AW    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSLOT-1:0]  load_en,
    input  logic [NSLOT*AW-1:0] op_dst,
    output logic [NSLOT-1:0]  pend_vld,
    output logic [NSLOT*AW-1:0] pend_dst
);
    typedef struct packed {
        logic [NSLOT-1:0]    vld;
        logic [NSLOT*AW-1:0] dst;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d.vld = load_en;
        pend_d.dst = op_dst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_vld = pend_q.vld;
    assign pend_dst = pend_q.dst;

    // R1: the first cycle after reset holds no pending load
    a_r1_flush: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_vld == '0));

    // R4: a pending entry exists only one cycle after a gated load issue
    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        a_r4_pend_src: assert property (@(posedge clk) disable iff (rst)
            pend_vld[s] |-> $past(load_en[s]));
    end
endmodule

// File: rtl/vrf_write_arb.sv
module vrf_write_arb #(
    parameter int W     = 16,
    parameter int NREG  = 16,
    parameter int NSLOT = 2,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSLOT-1:0]    pend_vld,
    input  logic [NSLOT*AW-1:0] pend_dst,
    input  logic [NSLOT*W-1:0]  ld_data,
    input  logic [NSLOT-1:0]    plain_en,
    input  logic [NSLOT*AW-1:0] op_dst,
    input  logic [NSLOT*W-1:0]  op_res,
    output logic [NREG-1:0]         wr_en,
    output logic [NREG-1:0][W-1:0]  wr_val
);
    // Later assignment wins: older loads first, then the current bundle,
    // each ordered from low slot to high slot.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            wr_en[r]  = 1'b0;
            wr_val[r] = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (pend_vld[s] && pend_dst[s*AW +: AW] == AW'(r)) begin
                    wr_en[r]  = 1'b1;
                    wr_val[r] = ld_data[s*W +: W];
                end
            end
            for (int s = 0; s < NSLOT; s++) begin
                if (plain_en[s] && op_dst[s*AW +: AW] == AW'(r)) begin
                    wr_en[r]  = 1'b1;
                    wr_val[r] = op_res[s*W +: W];
                end
            end
        end
    end

    // R9: with no plain write and no pending load, no register is written
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (plain_en == '0 && pend_vld == '0) |-> (wr_en == '0));

    // R3: every enabled plain op raises a write strobe on its destination
    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        a_r3_strobe: assert property (@(posedge clk) disable iff (rst)
            plain_en[s] |-> wr_en[op_dst[s*AW +: AW]]);
    end
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
    parameter int W     = vrf_pkg::VRF_W,
    parameter int NREG  = vrf_pkg::VRF_NREG,
    parameter int NSLOT = vrf_pkg::VRF_NSLOT,
    parameter int NRP   = vrf_pkg::VRF_NRP,
    parameter int NPRED = vrf_pkg::VRF_NPRED,
    localparam int AW   = $clog2(NREG),
    localparam int PW   = $clog2(NPRED),
    localparam int NRD  = NSLOT * NRP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NRD*AW-1:0]   rd_addr,
    output logic [NRD*W-1:0]    rd_data,
    input  logic [NSLOT-1:0]    op_valid,
    input  logic [NSLOT-1:0]    op_load,
    input  logic [NSLOT*PW-1:0] op_pidx,
    input  logic [NPRED-1:0]    pred_bits,
    input  logic [NSLOT*AW-1:0] op_dst,
    input  logic [NSLOT*W-1:0]  op_res,
    input  logic [NSLOT*W-1:0]  ld_data
);
    logic [NSLOT-1:0]        plain_en, load_en, pend_vld;
    logic [NSLOT*AW-1:0]     pend_dst;
    logic [NREG-1:0]         wr_en;
    logic [NREG-1:0][W-1:0]  wr_val;
    logic [W-1:0]            regs_d [NREG];
    logic [W-1:0]            regs_q [NREG];

    vrf_pred_gate #(.NSLOT(NSLOT), .NPRED(NPRED), .PW(PW)) pred_i (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_load(op_load), .op_pidx(op_pidx),
        .pred_bits(pred_bits), .plain_en(plain_en), .load_en(load_en)
    );

    vrf_load_pipe #(.NSLOT(NSLOT), .AW(AW)) pipe_i (
        .clk(clk), .rst(rst),
        .load_en(load_en), .op_dst(op_dst),
        .pend_vld(pend_vld), .pend_dst(pend_dst)
    );

    vrf_write_arb #(.W(W), .NREG(NREG), .NSLOT(NSLOT), .AW(AW)) arb_i (
        .clk(clk), .rst(rst),
        .pend_vld(pend_vld), .pend_dst(pend_dst), .ld_data(ld_data),
        .plain_en(plain_en), .op_dst(op_dst), .op_res(op_res),
        .wr_en(wr_en), .wr_val(wr_val)
    );

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            regs_d[r] = wr_en[r] ? wr_val[r] : regs_q[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= regs_d[r];
        end
    end

    // R2: reads come straight from committed state, no forwarding
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p*W +: W] = regs_q[rd_addr[p*AW +: AW]];
    end

    // R7 / R8: the highest slot of the current bundle always lands
    a_r7_top_slot: assert property (@(posedge clk) disable iff (rst)
        plain_en[NSLOT-1]
            |-> regs_d[op_dst[(NSLOT-1)*AW +: AW]] == op_res[(NSLOT-1)*W +: W]);
endmodule

// File: tb/vliw_regfile_tb_top.sv
module vliw_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    typedef struct packed {
        logic [1:0]  val;
        logic [1:0]  ld;
        logic [1:0]  p0;
        logic [1:0]  p1;
        logic [3:0]  d0;
        logic [3:0]  d1;
        logic [15:0] r0;
        logic [15:0] r1;
        logic [15:0] l0;
        logic [15:0] l1;
        logic [3:0]  ra;
        logic [15:0] ex;
    } vec_t;

    // bit 1 of val/ld is slot 1; pred_bits fixed to 4'b0100 (P2 true only)
    localparam vec_t VEC [NVEC] = '{
        '{2'b11,2'b00,2'd0,2'd0,4'd1,4'd2,16'h1111,16'h2222,16'h0,16'h0,4'd1,16'h0000},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd1,16'h1111},
        '{2'b01,2'b01,2'd0,2'd0,4'd3,4'd0,16'h0,16'h0,16'h0,16'h0,4'd2,16'h2222},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'hABCD,16'h0,4'd3,16'h0000},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd3,16'hABCD},
        '{2'b11,2'b10,2'd1,2'd3,4'd4,4'd5,16'h4444,16'h0,16'h0,16'h0,4'd4,16'h0000},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h1234,16'h5555,4'd4,16'h0000},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd5,16'h0000},
        '{2'b11,2'b00,2'd2,2'd0,4'd6,4'd6,16'h0606,16'h1616,16'h0,16'h0,4'd6,16'h0000},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd6,16'h1616},
        '{2'b11,2'b01,2'd0,2'd2,4'd7,4'd8,16'h0,16'h0808,16'h0,16'h0,4'd7,16'h0000},
        '{2'b01,2'b00,2'd0,2'd0,4'd7,4'd0,16'h0707,16'h0,16'h7777,16'h0,4'd8,16'h0808},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd7,16'h0707},
        '{2'b00,2'b00,2'd0,2'd0,4'd9,4'd9,16'h9999,16'h9999,16'h0,16'h0,4'd8,16'h0808},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd9,16'h0000},
        '{2'b10,2'b10,2'd0,2'd2,4'd0,4'd10,16'h0,16'h0,16'h0,16'h0,4'd1,16'h1111},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'hAAAA,4'd10,16'h0000},
        '{2'b00,2'b00,2'd0,2'd0,4'd0,4'd0,16'h0,16'h0,16'h0,16'h0,4'd10,16'hAAAA}
    };

    // which requirement each vector row checks
    localparam string TAG [NVEC] = '{
        "R2","R3/R6","R3","R10","R4","R2","R5","R5","R2",
        "R7","R2","R3","R8","R8","R9","R3","R10","R4"
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rd_addr = '0;
    logic [63:0] rd_data;
    logic [1:0]  op_valid = '0, op_load = '0;
    logic [3:0]  op_pidx = '0;
    logic [3:0]  pred_bits = 4'b0100;
    logic [7:0]  op_dst = '0;
    logic [31:0] op_res = '0, ld_data = '0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vliw_regfile dut_i (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .op_valid(op_valid), .op_load(op_load), .op_pidx(op_pidx),
        .pred_bits(pred_bits), .op_dst(op_dst), .op_res(op_res),
        .ld_data(ld_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = '0; op_load = '0; op_pidx = '0;
        op_dst = '0; op_res = '0; ld_data = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: every register reads 0 after reset, four per cycle
        for (int g = 0; g < 4; g++) begin
            rd_addr = {4'(4*g+3), 4'(4*g+2), 4'(4*g+1), 4'(4*g)};
            #1;
            for (int p = 0; p < 4; p++) check("R1 reset value", rd_data[p*16 +: 16], 16'h0);
            @(negedge clk);
        end
        rd_addr = '0;
        // vector table
        for (int i = 0; i < NVEC; i++) begin
            op_valid = VEC[i].val;
            op_load  = VEC[i].ld;
            op_pidx  = {VEC[i].p1, VEC[i].p0};
            op_dst   = {VEC[i].d1, VEC[i].d0};
            op_res   = {VEC[i].r1, VEC[i].r0};
            ld_data  = {VEC[i].l1, VEC[i].l0};
            rd_addr[3:0] = VEC[i].ra;
            #1;
            check(TAG[i], rd_data[15:0], VEC[i].ex);
            @(negedge clk);
        end
        idle();
        // R2: other read ports see the same committed state
        rd_addr = {4'd2, 4'd6, 4'd3, 4'd1};
        #1;
        check("R2 port1", rd_data[31:16], 16'hABCD);
        check("R2 port2", rd_data[47:32], 16'h1616);
        check("R2 port3", rd_data[63:48], 16'h2222);
        @(negedge clk);
        // R1: reset with a load in flight flushes it
        op_valid = 2'b01; op_load = 2'b01; op_dst = {4'd0, 4'd11};
        @(negedge clk);
        idle();
        ld_data = {16'h0, 16'hBEEF};
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ld_data = '0;
        rd_addr = {4'd2, 4'd6, 4'd1, 4'd11};
        #1;
        check("R1 flushed load", rd_data[15:0], 16'h0);
        check("R1 cleared reg", rd_data[31:16], 16'h0);
        @(negedge clk);
        #1;
        check("R1 no late commit", rd_data[15:0], 16'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule